// File: doc/BRIEF.md
# EEPROM Endurance Preconditioning Sequencer

This block runs the write-endurance preconditioning of a byte-wide parallel EEPROM before the device goes into a retention bake. After a start pulse, it writes the whole array a set number of times. Each write is a page load followed by an enforced program-time pause. Successive passes alternate between a checkerboard image and its bitwise inverse.

When the last write pass ends, the block makes one read pass. It holds each address for the full read access time, then compares the byte it reads with the image written last. It counts the mismatching bytes and reports that count together with a one-cycle completion pulse.

The memory side is a plain asynchronous parallel port with active-low chip, output and write enables. Array size, page size, clock rate, program time and access time are all parameters. The program-time wait and the access-time hold are derived in cycles from those parameters.

Top module: `eeprom_precond_seq`

## Requirements
- R1: After reset, all three memory strobes are high, `done_o` is low and `err_cnt_o` is zero.
- R2: Passes are numbered from 0. An even pass writes 8'h55 to every even address and 8'hAA to every odd address. An odd pass swaps those two values.
- R3: Each pass writes every address exactly once, in ascending order from 0. A page is 2**PAGE_W consecutive addresses, aligned to its size.
- R4: After the final byte of each page, the chip stays deselected for at least PROG_US*CLK_MHZ clock cycles before the next write or read.
- R5: The number of write passes equals `cycles_i` as captured at start. A value of 0 selects 220 passes.
- R6: In the read pass, each address is held with output enable low for ceil(ACCESS_NS*CLK_MHZ/1000) cycles, and the data is sampled at the end of that hold. The compare image is the image of the last write pass.
- R7: `err_cnt_o` counts the bytes read back that differ from the compare image. It saturates at all ones (2**ADDR_W-1) and is cleared when a run starts.
- R8: `done_o` is a single-cycle pulse at the end of the read pass. `err_cnt_o` holds its value until the next accepted start.
- R9: Write enable is low only while chip enable is low and output enable is high.
- R10: A start pulse that arrives while a run is in progress is ignored. The run keeps its pass count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run when idle |
| cycles_i | input | CNT_W | Number of write passes, 0 selects 220 |
| done_o | output | 1 | One-cycle pulse when the compare pass ends |
| err_cnt_o | output | ADDR_W | Saturating count of mismatching bytes |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |

## Verification
Four properties are checked on every cycle:
- the strobe interlock;
- the single-cycle width of the done pulse;
- the address holding still through each read hold;
- the error counter never wrapping once saturated.

Some behaviour only shows up across whole runs, so the bench scenarios cover it. That includes the alternating image order, the complete ascending sweep, the deselected pause after every page, the pass count including the default of 220, and an ignored mid-run start. The bench memory model returns corrupted data if a byte is sampled before the access hold is over. Injected bit faults then show that the count matches the faulty bytes and saturates when every byte fails.

// File: rtl/eeprom_precond_pkg.sv
package eeprom_precond_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_WWAIT,
    ST_RHOLD,
    ST_DONE
  } seq_state_e;

  // even pass: 0x55 on even addresses, 0xAA on odd; odd pass swaps them
  function automatic logic [7:0] image_byte(input logic addr_lsb, input logic inv);
    return (addr_lsb ^ inv) ? 8'hAA : 8'h55;
  endfunction

endpackage

// File: rtl/precond_timer.sv
module precond_timer #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of a window of val_i cycles
  assign expire_o = (cnt_q == W'(1));

endmodule

// File: rtl/precond_err_cnt.sv
module precond_err_cnt #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> (cnt_q == MAX));

endmodule

// File: rtl/eeprom_precond_seq.sv
module eeprom_precond_seq
  import eeprom_precond_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_W     = 7,
  parameter int CNT_W      = 16,
  parameter int DEF_PASSES = 220,
  parameter int CLK_MHZ    = 100,
  parameter int PROG_US    = 10000,
  parameter int ACCESS_NS  = 150
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cycles_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] err_cnt_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no
);

  localparam int PROG_CYC = PROG_US * CLK_MHZ;
  localparam int ACC_RAW  = (ACCESS_NS * CLK_MHZ + 999) / 1000;
  localparam int ACC_CYC  = (ACC_RAW > 0) ? ACC_RAW : 1;
  localparam int TMR_W    = $clog2(PROG_CYC + ACC_CYC + 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  pass_q, pass_d, passes_q, passes_d;
  logic              inv_q, inv_d;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              err_inc, err_clr;
  logic              page_end, addr_last;

  assign page_end  = &addr_q[PAGE_W-1:0];
  assign addr_last = &addr_q;

  precond_timer #(.W(TMR_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expire_o (tmr_exp)
  );

  precond_err_cnt #(.W(ADDR_W)) i_err_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (err_clr),
    .inc_i  (err_inc),
    .cnt_o  (err_cnt_o)
  );

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    pass_d   = pass_q;
    passes_d = passes_q;
    inv_d    = inv_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    err_inc  = 1'b0;
    err_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        passes_d = (cycles_i == '0) ? CNT_W'(DEF_PASSES) : cycles_i;
        pass_d   = '0;
        inv_d    = 1'b0;
        addr_d   = '0;
        err_clr  = 1'b1;
        state_d  = ST_WSETUP;
      end
      ST_WSETUP: state_d = ST_WPULSE;
      ST_WPULSE: state_d = ST_WHOLD;
      ST_WHOLD: begin
        if (page_end) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(PROG_CYC);
          state_d  = ST_WWAIT;
        end else begin
          addr_d  = addr_q + 1'b1;
          state_d = ST_WSETUP;
        end
      end
      ST_WWAIT: if (tmr_exp) begin
        addr_d  = addr_q + 1'b1;
        state_d = ST_WSETUP;
        if (addr_last) begin
          if (pass_q == passes_q - 1'b1) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(ACC_CYC);
            state_d  = ST_RHOLD;
          end else begin
            pass_d = pass_q + 1'b1;
            inv_d  = ~inv_q;
          end
        end
      end
      ST_RHOLD: if (tmr_exp) begin
        err_inc = (mem_rdata_i != image_byte(addr_q[0], inv_q));
        if (addr_last) begin
          state_d = ST_DONE;
        end else begin
          addr_d   = addr_q + 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(ACC_CYC);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      pass_q   <= '0;
      passes_q <= '0;
      inv_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      pass_q   <= pass_d;
      passes_q <= passes_d;
      inv_q    <= inv_d;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = image_byte(addr_q[0], inv_q);
  assign mem_ce_no   = !(state_q inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RHOLD});
  assign mem_oe_no   = (state_q != ST_RHOLD);
  assign mem_we_no   = (state_q != ST_WPULSE);
  assign done_o      = (state_q == ST_DONE);

  assert_we_interlock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_read_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no && !$past(mem_oe_no) && !$past(tmr_exp)) |-> $stable(mem_addr_o));

endmodule

// File: tb/test_eeprom_precond_seq.sv
module test_eeprom_precond_seq;

  localparam int ADDR_W = 5;
  localparam int PAGE_W = 3;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int PROG   = 3 * 2;                // PROG_US * CLK_MHZ
  localparam int ACC    = (1500 * 2 + 999) / 1000;  // 3 cycles

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  cycles = '0;
  logic              done;
  logic [ADDR_W-1:0] err_cnt;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata;
  logic [7:0]        rdata;
  logic              ce_n, oe_n, we_n;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [7:0] mem  [DEPTH];
  logic [7:0] mask [DEPTH];
  int wr_cnt, wr_bad, gap_bad, ilk_bad, desel, stab;
  logic [ADDR_W-1:0] prev_addr;
  logic prev_we;

  always #4 clk = ~clk;

  eeprom_precond_seq #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .DEF_PASSES(220),
    .CLK_MHZ(2), .PROG_US(3), .ACCESS_NS(1500)
  ) i_eeprom_precond_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cycles_i(cycles),
    .done_o(done), .err_cnt_o(err_cnt), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n)
  );

  // memory model: data is wrong until the address has been held ACC cycles
  assign rdata = (stab >= ACC) ? (mem[addr] ^ mask[addr]) : ~(mem[addr] ^ mask[addr]);

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_we = 1'b1; stab = 0; desel = 0; prev_addr = '0;
    end else begin
      if (!we_n && (ce_n || !oe_n)) ilk_bad++;
      if (ce_n) desel++;
      if (!prev_we && we_n) begin
        int ea, ep;
        logic [7:0] ed;
        ea = wr_cnt % DEPTH;
        ep = wr_cnt / DEPTH;
        ed = (((ea & 1) ^ (ep & 1)) != 0) ? 8'hAA : 8'h55;
        if (int'(addr) != ea || wdata != ed) wr_bad++;
        if ((ea % PAGE) == 0 && wr_cnt != 0 && desel < PROG) gap_bad++;
        mem[addr] = wdata;
        wr_cnt++;
        desel = 0;
      end
      prev_we = we_n;
      if (!oe_n) stab = (addr == prev_addr && stab > 0) ? stab + 1 : 1;
      else stab = 0;
      prev_addr = addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected done earlier", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int passes_in, input int exp_passes, input int exp_err,
                     input bit mid_start);
    @(posedge clk); #1;
    wr_cnt = 0; wr_bad = 0; gap_bad = 0;
    cycles = CNT_W'(passes_in); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (mid_start) begin
      repeat (50) @(posedge clk);
      #1; cycles = 16'd7; start = 1'b1;   // R10: must be ignored
      @(posedge clk); #1; start = 1'b0;
    end
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(err_cnt == ADDR_W'(exp_err), "R7 R6 error count", int'(err_cnt), exp_err);
    chk(wr_cnt == exp_passes * DEPTH, "R5 R10 write count", wr_cnt, exp_passes * DEPTH);
    chk(wr_bad == 0, "R2 R3 image and address order", wr_bad, 0);
    chk(gap_bad == 0, "R4 program wait after page", gap_bad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", int'(done), 0);
    repeat (5) @(negedge clk);
    chk(err_cnt == ADDR_W'(exp_err), "R8 count held", int'(err_cnt), exp_err);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'h00; mask[i] = 8'h00; end
    ilk_bad = 0; wr_cnt = 0; wr_bad = 0; gap_bad = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1 strobes high in reset", {ce_n, oe_n, we_n}, 7);
    chk(!done && err_cnt == '0, "R1 done and count clear", int'(err_cnt), 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce_n && oe_n && we_n && !done, "R1 idle after reset", {ce_n, oe_n, we_n}, 7);

    run(3, 3, 0, 1'b1);                 // odd count, start pulse mid-run (R10)

    mask[0] = 8'h02; mask[3] = 8'h01; mask[10] = 8'h80; mask[17] = 8'hFF; mask[31] = 8'h10;
    run(4, 4, 5, 1'b0);                 // even count: compare against inverse image

    for (int i = 0; i < DEPTH; i++) mask[i] = 8'h00;
    run(0, 220, 0, 1'b0);               // R5 default pass count

    for (int i = 0; i < DEPTH; i++) mask[i] = 8'h01;
    run(1, 1, DEPTH - 1, 1'b0);         // R7 saturation: every byte fails

    chk(ilk_bad == 0, "R9 write enable interlock", ilk_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule